// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

This block is a parallel-in, serial-out shift register with a configurable number of stages (eight by default). It runs entirely in one fast system clock domain. The shift clock, the clock-inhibit line, the active-low load control, the serial input and the parallel data inputs are all external signals. Each one passes through a two-flop synchronizer before the logic uses it.

The shift clock and the inhibit line are equal partners. The logic ORs their synchronized levels into one gated clock. A rising edge of that gated clock shifts the register by one place: the first stage (A) takes the serial input, every stage passes its bit to the next, and the last stage (H) drives the serial output. A complementary serial output is also provided.

While the load control is low, the parallel inputs are copied into all stages on every system clock. The copy ignores the gated clock and the serial input. While the load control is high, the parallel inputs are not looked at.

Top module: `piso_gated_shreg`

## Requirements
- R1: A synchronous active-high reset clears every stage and the gated-clock edge history. After reset, ser_q_o is 0 and ser_qn_o is 1.
- R2: While load_n_i is low, each stage copies its parallel input on every cycle. par_i[0] is stage A and par_i[STAGES-1] is stage H, so ser_q_o shows par_i[STAGES-1]. The copy happens whatever the levels of shift_clk_i, clk_hold_i and ser_i.
- R3: While load_n_i is high, a rising edge of (shift_clk_i OR clk_hold_i) shifts the register once. Stage A takes ser_i, stage k takes stage k-1, and ser_q_o shows stage H.
- R4: A rising edge of clk_hold_i while shift_clk_i is low shifts the register exactly as a shift_clk_i edge does.
- R5: The register does not shift when the OR does not rise. This covers toggling clk_hold_i while shift_clk_i is high, and toggling shift_clk_i while clk_hold_i is high.
- R6: While load_n_i is high, changes on par_i have no effect on the stages.
- R7: A gated-clock rising edge that occurs while load_n_i is low is dropped. The load wins, and no shift is applied once load_n_i returns high.
- R8: ser_qn_o is always the logical complement of ser_q_o.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_clk_i | input | 1 | Shift clock, one input of the gated clock |
| clk_hold_i | input | 1 | Clock-inhibit line, the other input of the gated clock |
| load_n_i | input | 1 | Active-low level-sensitive parallel load |
| ser_i | input | 1 | Serial data entering stage A |
| par_i | input | STAGES | Parallel data, bit 0 is stage A |
| ser_q_o | output | 1 | Serial output, stage H |
| ser_qn_o | output | 1 | Complement of ser_q_o |

## Verification
A gated-clock rising edge and an active load can land in the same system cycle. The bench provokes this by pulsing the shift clock while load_n_i is held low with a fresh pattern. It then releases the load and shifts the register out bit by bit. The scoreboard expects the loaded pattern with no extra shift applied, which shows that the load took priority and the edge was dropped.

// File: rtl/piso_pkg.sv
package piso_pkg;
  localparam int unsigned DEF_STAGES     = 8;
  localparam int unsigned DEF_SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } stage_op_e;
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
  parameter int unsigned W     = 1,
  parameter int unsigned DEPTH = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[DEPTH-1];
endmodule

// File: rtl/piso_edge.sv
module piso_edge (
  input  logic clk,
  input  logic rst,
  input  logic clk_s,
  input  logic hold_s,
  output logic fire_o
);
  logic gated;
  logic gated_d;

  assign gated = clk_s | hold_s;

  always_ff @(posedge clk) begin
    if (rst) gated_d <= 1'b0;
    else     gated_d <= gated;
  end

  assign fire_o = gated & ~gated_d;

  AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fire_o |=> !fire_o); // R3
  AST_NO_FIRE_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
    ($past(gated) && gated) |-> !fire_o); // R5
endmodule

// File: rtl/piso_stages.sv
module piso_stages
  import piso_pkg::*;
#(
  parameter int unsigned N = DEF_STAGES
) (
  input  logic          clk,
  input  logic          rst,
  input  stage_op_e     op,
  input  logic          ser,
  input  logic [N-1:0]  par,
  output logic [N-1:0]  stg_o
);
  function automatic logic [N-1:0] shift_next(input logic [N-1:0] cur, input logic s);
    shift_next = {cur[N-2:0], s};
  endfunction

  logic [N-1:0] stg;
  logic [N-1:0] stg_nxt;

  always_comb begin
    unique case (op)
      OP_LOAD:  stg_nxt = par;
      OP_SHIFT: stg_nxt = shift_next(stg, ser);
      default:  stg_nxt = stg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= stg_nxt;
  end

  assign stg_o = stg;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> stg == '0); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (op == OP_IDLE) |=> $stable(stg)); // R6
endmodule

// File: rtl/piso_gated_shreg.sv
module piso_gated_shreg
  import piso_pkg::*;
#(
  parameter int unsigned STAGES     = DEF_STAGES,
  parameter int unsigned SYNC_DEPTH = DEF_SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_clk_i,
  input  logic              clk_hold_i,
  input  logic              load_n_i,
  input  logic              ser_i,
  input  logic [STAGES-1:0] par_i,
  output logic              ser_q_o,
  output logic              ser_qn_o
);
  localparam int unsigned BUS_W = STAGES + 4;
  localparam logic [BUS_W-1:0] SYNC_RST = {1'b1, {(BUS_W-1){1'b0}}};

  logic [BUS_W-1:0]  raw_bus;
  logic [BUS_W-1:0]  syn_bus;
  logic              s_load_n;
  logic              s_hold;
  logic              s_clk;
  logic              s_ser;
  logic [STAGES-1:0] s_par;
  logic              fire;
  stage_op_e         op;
  logic [STAGES-1:0] stages;

  assign raw_bus = {load_n_i, clk_hold_i, shift_clk_i, ser_i, par_i};

  piso_sync #(.W(BUS_W), .DEPTH(SYNC_DEPTH), .RST_VAL(SYNC_RST)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   (raw_bus),
    .q   (syn_bus)
  );

  assign {s_load_n, s_hold, s_clk, s_ser, s_par} = syn_bus;

  piso_edge edge_i (
    .clk    (clk),
    .rst    (rst),
    .clk_s  (s_clk),
    .hold_s (s_hold),
    .fire_o (fire)
  );

  always_comb begin
    if (!s_load_n)  op = OP_LOAD;
    else if (fire)  op = OP_SHIFT;
    else            op = OP_IDLE;
  end

  piso_stages #(.N(STAGES)) stages_i (
    .clk   (clk),
    .rst   (rst),
    .op    (op),
    .ser   (s_ser),
    .par   (s_par),
    .stg_o (stages)
  );

  assign ser_q_o  = stages[STAGES-1];
  assign ser_qn_o = ~stages[STAGES-1];

  AST_LOAD_SHOWS_H: assert property (@(posedge clk) disable iff (rst)
    !s_load_n |=> ser_q_o == $past(s_par[STAGES-1])); // R2
  AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (rst)
    (fire && s_load_n) |=> ser_q_o == $past(stages[STAGES-2])); // R3
  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (fire && s_load_n) |=> stages[0] == $past(s_ser)); // R4
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (fire && !s_load_n) |=> stages == $past(s_par)); // R7
  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    ser_qn_o != ser_q_o); // R8
endmodule

// File: tb/piso_gated_shreg_tb_top.sv
module piso_gated_shreg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int SETTLE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_clk_i = 1'b0;
  logic clk_hold_i = 1'b0;
  logic load_n_i = 1'b1;
  logic ser_i = 1'b0;
  logic [N-1:0] par_i = '0;
  logic ser_q_o, ser_qn_o;

  int n_checks = 0;
  int n_fail = 0;
  logic [N-1:0] model = '0;
  bit    exp_q[$];
  string tag_q[$];
  event  mon_ev;
  bit    done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  piso_gated_shreg #(.STAGES(N)) dut_i (
    .clk(clk), .rst(rst), .shift_clk_i(shift_clk_i), .clk_hold_i(clk_hold_i),
    .load_n_i(load_n_i), .ser_i(ser_i), .par_i(par_i),
    .ser_q_o(ser_q_o), .ser_qn_o(ser_qn_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_h(input string tag);
    exp_q.push_back(model[N-1]);
    tag_q.push_back(tag);
    -> mon_ev;
    #1;
  endtask

  // model shift: bit i takes bit i-1, bit 0 takes serial in
  task automatic model_shift(input logic s);
    for (int i = N-1; i > 0; i--) model[i] = model[i-1];
    model[0] = s;
  endtask

  task automatic do_load(input logic [N-1:0] p);
    par_i = p; load_n_i = 1'b0;
    tick(SETTLE);
    load_n_i = 1'b1;
    tick(SETTLE);
    model = p;
  endtask

  task automatic pulse_clk(input logic s, input bit use_hold);
    ser_i = s;
    if (use_hold) clk_hold_i = 1'b1; else shift_clk_i = 1'b1;
    tick(SETTLE);
    if (use_hold) clk_hold_i = 1'b0; else shift_clk_i = 1'b0;
    tick(SETTLE);
    model_shift(s);
  endtask

  initial begin : monitor
    forever begin
      @(mon_ev);
      while (exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_checks++;
        if (ser_q_o !== e || ser_qn_o !== ~e) begin
          n_fail++;
          $display("FAIL %s: q=%b qn=%b expected q=%b qn=%b", t, ser_q_o, ser_qn_o, e, ~e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: timeout, expected run to finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : driver
    tick(3);
    rst = 1'b0;
    tick(SETTLE);
    model = '0;
    expect_h("R1 reset state");

    // eight shifts after a load
    par_i = 8'b1010_0101; load_n_i = 1'b0;
    tick(SETTLE);
    model = par_i;
    expect_h("R2 load shows H");
    par_i = 8'b0010_0101;
    tick(SETTLE);
    model = par_i;
    expect_h("R2 load is continuous");
    shift_clk_i = 1'b1; ser_i = 1'b1; tick(SETTLE);
    shift_clk_i = 1'b0; tick(SETTLE);
    expect_h("R2 load ignores clock and serial");
    load_n_i = 1'b1; tick(SETTLE);
    par_i = 8'b1111_1111; tick(SETTLE);
    expect_h("R6 par ignored while load high");
    for (int k = 0; k < N; k++) begin
      pulse_clk(k[0], 1'b0);
      expect_h($sformatf("R3 shift %0d", k));
    end

    // inhibit-driven shifts
    do_load(8'b0110_1001);
    expect_h("R2 load before inhibit shifts");
    for (int k = 0; k < 4; k++) begin
      pulse_clk(~k[1], 1'b1);
      expect_h($sformatf("R4 inhibit shift %0d", k));
    end

    // no rise of OR: inhibit toggles while clock high, then clock toggles while inhibit high
    do_load(8'b1011_0000);
    shift_clk_i = 1'b1; tick(SETTLE);
    model_shift(1'b0); ser_i = 1'b0;
    expect_h("R3 shift before gating");
    clk_hold_i = 1'b1; tick(SETTLE);
    clk_hold_i = 1'b0; tick(SETTLE);
    clk_hold_i = 1'b1; tick(SETTLE);
    shift_clk_i = 1'b0; tick(SETTLE);
    shift_clk_i = 1'b1; tick(SETTLE);
    shift_clk_i = 1'b0; tick(SETTLE);
    clk_hold_i = 1'b0; tick(SETTLE);
    expect_h("R5 no shift without OR rise");
    pulse_clk(1'b0, 1'b0);
    expect_h("R5 next bit intact");

    // load in the middle of a shift sequence with an edge during load
    do_load(8'b1100_1100);
    pulse_clk(1'b1, 1'b0);
    expect_h("R3 shift before mid load");
    par_i = 8'b0101_0011; load_n_i = 1'b0; tick(SETTLE);
    shift_clk_i = 1'b1; tick(SETTLE);
    shift_clk_i = 1'b0; tick(SETTLE);
    load_n_i = 1'b1; tick(SETTLE);
    model = 8'b0101_0011;
    expect_h("R7 load wins over edge");
    for (int k = 0; k < N; k++) begin
      pulse_clk(1'b1, k[0]);
      expect_h($sformatf("R7 R8 post-load shift %0d", k));
    end

    // reset mid-run
    rst = 1'b1; tick(2); rst = 1'b0; tick(SETTLE);
    model = '0;
    expect_h("R1 reset clears stages");
    pulse_clk(1'b0, 1'b0);
    expect_h("R1 cleared stage G");

    tick(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule